// File: doc/BRIEF.md
# Drive Seek Tracker with Disk-Change Latch

This block holds, for each of a small set of drives, the state that seek-type commands change and that a sense-interrupt command reports. That state is the present cylinder number, the head last addressed, a flag showing a finished seek that has not yet been reported, and a disk-change latch. A command decoder upstream gives it one-cycle strobes with their drive, head and cylinder operands. The strobes are an absolute seek, an inward relative seek, an outward relative seek and a sense interrupt. The block also takes a media-present level per drive.

A seek finishes in the cycle it is accepted. Physical step timing is modelled elsewhere. The new cylinder and a pending flag are registered for the addressed drive. A sense interrupt reports the lowest-numbered drive with a pending flag, using a status byte and the cylinder, and then clears that flag. If no flag is pending, it returns a single idle byte. The disk-change latch is set while a drive has no media. It clears only when a seek actually moves the head while media is present.

A view-select input picks which drive's cylinder and digital-input byte appear on the outputs.

Top module: `seek_tracker`

## Requirements
- R1: After reset every drive has cylinder 0, no pending seek report, and a set disk-change latch, so `dir_o` reads 0x80. Bits 6:0 of `dir_o` are always 0, and `int_pend_o` is 0.
- R2: While a drive has no media, its latch reads as set. This holds through any number of reads of `dir_o` and through seeks that step the head. Removing media sets the latch again within one clock.
- R3: Inserting media does not clear the latch. A seek whose target equals the present cylinder does not step the head and also leaves the latch set.
- R4: A seek whose target differs from the present cylinder clears the latch of the addressed drive, but only if that drive has media. Other drives' latches are unchanged.
- R5: An absolute seek (`seek_abs_i`) sets the addressed drive's cylinder to `cyl_arg_i` and marks a seek report pending, visible one clock later.
- R6: An inward relative seek (`seek_in_i`) adds `cyl_arg_i` to the present cylinder. The result saturates at 255.
- R7: An outward relative seek (`seek_out_i`) subtracts `cyl_arg_i` from the present cylinder. The result saturates at 0.
- R8: A sense interrupt with no report pending pulses `sense_done_o`, with `sense_two_o` = 0 and `sense_b0_o` = 0x80.
- R9: A sense interrupt with a report pending returns `sense_two_o` = 1. The status byte `sense_b0_o` is 0x20 OR (head << 2) OR drive number, and `sense_b1_o` is that drive's cylinder. That drive's pending flag is cleared. `int_pend_o` falls once no flag remains.
- R10: When several drives have reports pending, sense interrupts report them in order of increasing drive number.
- R11: When strobes coincide, the absolute seek wins over the inward seek, which wins over the outward seek, which wins over sense. A sense interrupt that coincides with any seek is ignored, so `sense_done_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seek_abs_i | input | 1 | Absolute seek strobe |
| seek_in_i | input | 1 | Inward relative seek strobe |
| seek_out_i | input | 1 | Outward relative seek strobe |
| sense_i | input | 1 | Sense-interrupt strobe |
| drv_sel_i | input | 2 | Drive operand of the command |
| head_sel_i | input | 1 | Head operand of the command |
| cyl_arg_i | input | 8 | Cylinder target or relative step count |
| media_i | input | 4 | Media present, one bit per drive |
| view_drv_i | input | 2 | Drive shown on `pcn_o` and `dir_o` |
| pcn_o | output | 8 | Present cylinder of the viewed drive |
| dir_o | output | 8 | Digital-input byte, bit 7 is the viewed drive's disk-change latch |
| int_pend_o | output | 1 | Some drive has an unreported seek |
| sense_done_o | output | 1 | One-cycle pulse: a sense interrupt was answered |
| sense_two_o | output | 1 | The answer has two bytes |
| sense_b0_o | output | 8 | First answer byte (status) |
| sense_b1_o | output | 8 | Second answer byte (cylinder) |

## Verification
A wrong cylinder register shows on `pcn_o` one clock after the seek that wrote it. It shows again in the second sense byte when that report is read out. A latch that is wrongly cleared or kept shows on bit 7 of `dir_o` one clock after the seek or media change that should have decided it. A pending flag or priority error stays hidden until the next sense interrupt, which then returns the wrong drive, the wrong status byte, or a one-byte answer where two were due.

// File: rtl/fdt_pkg.sv
package fdt_pkg;

    typedef enum logic [1:0] {
        MV_NONE = 2'd0,
        MV_ABS  = 2'd1,
        MV_IN   = 2'd2,
        MV_OUT  = 2'd3
    } move_e;

    localparam logic [7:0] ST0_SEEK_END = 8'h20;
    localparam logic [7:0] ST0_IDLE     = 8'h80;

    typedef struct packed {
        logic       done;
        logic       two;
        logic [7:0] b0;
        logic [7:0] b1;
    } sense_res_t;

endpackage

// File: rtl/fdt_target_calc.sv
module fdt_target_calc
    import fdt_pkg::*;
#(
    parameter int CYL_W = 8
) (
    input  move_e            kind_i,
    input  logic [CYL_W-1:0] pcn_i,
    input  logic [CYL_W-1:0] arg_i,
    output logic [CYL_W-1:0] tgt_o
);

    logic [CYL_W:0] sum;

    always_comb begin
        sum = {1'b0, pcn_i} + {1'b0, arg_i};
        unique case (kind_i)
            MV_ABS:  tgt_o = arg_i;
            MV_IN:   tgt_o = sum[CYL_W] ? {CYL_W{1'b1}} : sum[CYL_W-1:0];
            MV_OUT:  tgt_o = (arg_i > pcn_i) ? '0 : pcn_i - arg_i;
            default: tgt_o = pcn_i;
        endcase
    end

endmodule

// File: rtl/fdt_drive_slot.sv
module fdt_drive_slot #(
    parameter int CYL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic [CYL_W-1:0] tgt_i,
    input  logic             head_i,
    input  logic             media_i,
    input  logic             ack_i,
    output logic [CYL_W-1:0] pcn_o,
    output logic             head_o,
    output logic             pend_o,
    output logic             chg_o
);

    typedef struct packed {
        logic [CYL_W-1:0] pcn;
        logic             head;
        logic             pend;
        logic             chg;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (hit_i) begin
            s_d.pcn  = tgt_i;
            s_d.head = head_i;
            s_d.pend = 1'b1;
            if (media_i && (tgt_i != s_q.pcn)) begin
                s_d.chg = 1'b0;
            end
        end else if (ack_i) begin
            s_d.pend = 1'b0;
        end
        if (!media_i) begin
            s_d.chg = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{pcn: '0, head: 1'b0, pend: 1'b0, chg: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign pcn_o  = s_q.pcn;
    assign head_o = s_q.head;
    assign pend_o = s_q.pend;
    assign chg_o  = s_q.chg;

    // R2: no media means the latch reads set on the next cycle
    a_r2_absent_sets: assert property (@(posedge clk) disable iff (!rst_n)
        !media_i |=> s_q.chg);

    // R4: the latch only falls when the cylinder really changed
    a_r4_clear_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.chg) |-> ($past(s_q.pcn) != s_q.pcn));

    // R5: the cylinder only changes after a command addressed this drive
    a_r5_pcn_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.pcn) |-> $past(hit_i));

    // R9: an acknowledged report is gone on the next cycle
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !hit_i) |=> !s_q.pend);

endmodule

// File: rtl/fdt_sense_pick.sv
module fdt_sense_pick #(
    parameter int NUM_DRIVES = 4,
    localparam int DRV_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic [NUM_DRIVES-1:0] pend_i,
    output logic                  found_o,
    output logic [DRV_W-1:0]      idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_DRIVES - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                found_o = 1'b1;
                idx_o   = DRV_W'(i);
            end
        end
    end

endmodule

// File: rtl/seek_tracker.sv
module seek_tracker
    import fdt_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    parameter int CYL_W      = 8,
    localparam int DRV_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  seek_abs_i,
    input  logic                  seek_in_i,
    input  logic                  seek_out_i,
    input  logic                  sense_i,
    input  logic [DRV_W-1:0]      drv_sel_i,
    input  logic                  head_sel_i,
    input  logic [CYL_W-1:0]      cyl_arg_i,
    input  logic [NUM_DRIVES-1:0] media_i,
    input  logic [DRV_W-1:0]      view_drv_i,
    output logic [CYL_W-1:0]      pcn_o,
    output logic [7:0]            dir_o,
    output logic                  int_pend_o,
    output logic                  sense_done_o,
    output logic                  sense_two_o,
    output logic [7:0]            sense_b0_o,
    output logic [7:0]            sense_b1_o
);

    move_e                 kind;
    logic                  sense_act;
    logic [CYL_W-1:0]      pcn_w [NUM_DRIVES];
    logic [NUM_DRIVES-1:0] head_w, pend_w, chg_w, hit_w, ack_w;
    logic [CYL_W-1:0]      tgt;
    logic                  found;
    logic [DRV_W-1:0]      pick;
    sense_res_t            r_d, r_q;

    always_comb begin
        if (seek_abs_i)      kind = MV_ABS;
        else if (seek_in_i)  kind = MV_IN;
        else if (seek_out_i) kind = MV_OUT;
        else                 kind = MV_NONE;
        sense_act = sense_i && (kind == MV_NONE);
    end

    fdt_target_calc #(.CYL_W(CYL_W)) i_calc (
        .kind_i (kind),
        .pcn_i  (pcn_w[drv_sel_i]),
        .arg_i  (cyl_arg_i),
        .tgt_o  (tgt)
    );

    fdt_sense_pick #(.NUM_DRIVES(NUM_DRIVES)) i_pick (
        .pend_i  (pend_w),
        .found_o (found),
        .idx_o   (pick)
    );

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_slot
        assign hit_w[g] = (kind != MV_NONE) && (drv_sel_i == DRV_W'(g));
        assign ack_w[g] = sense_act && found && (pick == DRV_W'(g));

        fdt_drive_slot #(.CYL_W(CYL_W)) i_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit_i   (hit_w[g]),
            .tgt_i   (tgt),
            .head_i  (head_sel_i),
            .media_i (media_i[g]),
            .ack_i   (ack_w[g]),
            .pcn_o   (pcn_w[g]),
            .head_o  (head_w[g]),
            .pend_o  (pend_w[g]),
            .chg_o   (chg_w[g])
        );
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = sense_act;
        if (sense_act) begin
            if (found) begin
                r_d.two = 1'b1;
                r_d.b0  = ST0_SEEK_END | (8'(head_w[pick]) << 2) | 8'(pick);
                r_d.b1  = 8'(pcn_w[pick]);
            end else begin
                r_d.two = 1'b0;
                r_d.b0  = ST0_IDLE;
                r_d.b1  = 8'h00;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pcn_o        = pcn_w[view_drv_i];
    assign dir_o        = {chg_w[view_drv_i], 7'b0};
    assign int_pend_o   = |pend_w;
    assign sense_done_o = r_q.done;
    assign sense_two_o  = r_q.two;
    assign sense_b0_o   = r_q.b0;
    assign sense_b1_o   = r_q.b1;

    // R8: a one-byte answer only when nothing was pending before the sense
    a_r8_idle_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_done_o && !sense_two_o) |-> $past(!int_pend_o));

    // R11: a seek strobe keeps a coincident sense from being answered
    a_r11_seek_blocks_sense: assert property (@(posedge clk) disable iff (!rst_n)
        (seek_abs_i || seek_in_i || seek_out_i) |=> !sense_done_o);

    // R9: a two-byte answer always carries the seek-end status bit
    a_r9_report_status: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_done_o && sense_two_o) |-> (sense_b0_o[7:5] == 3'b001));

endmodule

// File: tb/test_seek_tracker.sv
module test_seek_tracker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       seek_abs_i = 0, seek_in_i = 0, seek_out_i = 0, sense_i = 0;
    logic [1:0] drv_sel_i = 0;
    logic       head_sel_i = 0;
    logic [7:0] cyl_arg_i = 0;
    logic [3:0] media_i = 0;
    logic [1:0] view_drv_i = 0;
    logic [7:0] pcn_o, dir_o, sense_b0_o, sense_b1_o;
    logic       int_pend_o, sense_done_o, sense_two_o;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    seek_tracker i_seek_tracker (
        .clk(clk), .rst_n(rst_n),
        .seek_abs_i(seek_abs_i), .seek_in_i(seek_in_i), .seek_out_i(seek_out_i),
        .sense_i(sense_i), .drv_sel_i(drv_sel_i), .head_sel_i(head_sel_i),
        .cyl_arg_i(cyl_arg_i), .media_i(media_i), .view_drv_i(view_drv_i),
        .pcn_o(pcn_o), .dir_o(dir_o), .int_pend_o(int_pend_o),
        .sense_done_o(sense_done_o), .sense_two_o(sense_two_o),
        .sense_b0_o(sense_b0_o), .sense_b1_o(sense_b1_o)
    );

    // op: 0 absolute, 1 inward, 2 outward; fields {op, drv, head, cyl, expected pcn}
    localparam logic [20:0] TBL [8] = '{
        {2'd0, 2'd0, 1'b0, 8'd5,   8'd5},
        {2'd1, 2'd0, 1'b0, 8'd3,   8'd8},
        {2'd2, 2'd0, 1'b0, 8'd10,  8'd0},
        {2'd1, 2'd1, 1'b0, 8'd200, 8'd200},
        {2'd1, 2'd1, 1'b0, 8'd100, 8'd255},
        {2'd2, 2'd1, 1'b0, 8'd55,  8'd200},
        {2'd0, 2'd2, 1'b1, 8'd0,   8'd0},
        {2'd0, 2'd3, 1'b0, 8'd77,  8'd77}
    };

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h, expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic issue(bit a, bit i, bit o, bit s, logic [1:0] d, bit h, logic [7:0] c);
        @(negedge clk);
        seek_abs_i = a; seek_in_i = i; seek_out_i = o; sense_i = s;
        drv_sel_i = d; head_sel_i = h; cyl_arg_i = c;
        @(negedge clk);
        seek_abs_i = 0; seek_in_i = 0; seek_out_i = 0; sense_i = 0;
    endtask

    task automatic view(logic [1:0] d);
        view_drv_i = d;
        #1;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got 0x00, expected 0x01");
        finish_run();
    end

    initial begin
        media_i = 4'b0000;
        do_reset();

        // R1 reset state on every drive
        for (int d = 0; d < 4; d++) begin
            view(2'(d));
            chk("R1 pcn", pcn_o, 8'h00);
            chk("R1 dir", dir_o, 8'h80);
        end
        chk("R1 int_pend", {7'b0, int_pend_o}, 8'h00);

        // R8 idle sense
        issue(0, 0, 0, 1, 2'd0, 0, 8'd0);
        chk("R8 done", {7'b0, sense_done_o}, 8'h01);
        chk("R8 len", {7'b0, sense_two_o}, 8'h00);
        chk("R8 byte", sense_b0_o, 8'h80);

        // R2 repeated reads and a stepping seek without media
        view(2'd0);
        chk("R2 read1", dir_o, 8'h80);
        chk("R2 read2", dir_o, 8'h80);
        issue(1, 0, 0, 0, 2'd0, 0, 8'd1);
        chk("R2 step no media", dir_o, 8'h80);
        chk("R5 pcn", pcn_o, 8'd1);
        chk("R5 pending", {7'b0, int_pend_o}, 8'h01);

        // R9 report of drive 0 head 0
        issue(0, 0, 0, 1, 2'd0, 0, 8'd0);
        chk("R9 len", {7'b0, sense_two_o}, 8'h01);
        chk("R9 st0", sense_b0_o, 8'h20);
        chk("R9 pcn", sense_b1_o, 8'd1);
        chk("R9 cleared", {7'b0, int_pend_o}, 8'h00);

        // R3 insertion and same-cylinder seek keep the latch
        media_i = 4'b0011;
        @(negedge clk);
        view(2'd0);
        chk("R3 insert", dir_o, 8'h80);
        issue(1, 0, 0, 0, 2'd0, 0, 8'd1);
        chk("R3 same cyl", dir_o, 8'h80);

        // R4 real step clears only the addressed drive
        issue(1, 0, 0, 0, 2'd0, 0, 8'd2);
        chk("R4 cleared", dir_o, 8'h00);
        view(2'd1);
        chk("R4 other drive", dir_o, 8'h80);

        // R2 eject sets again, stepping keeps it set
        media_i = 4'b0010;
        @(negedge clk);
        view(2'd0);
        chk("R2 eject", dir_o, 8'h80);
        issue(1, 0, 0, 0, 2'd0, 0, 8'd5);
        chk("R2 step after eject", dir_o, 8'h80);
        chk("R5 pcn after eject", pcn_o, 8'd5);

        for (int k = 0; k < 8; k++) begin
            if (int_pend_o) issue(0, 0, 0, 1, 2'd0, 0, 8'd0);
        end

        // R10 ordering of several reports
        issue(1, 0, 0, 0, 2'd2, 1, 8'd9);
        issue(1, 0, 0, 0, 2'd1, 0, 8'd3);
        chk("R10 pending", {7'b0, int_pend_o}, 8'h01);
        issue(0, 0, 0, 1, 2'd0, 0, 8'd0);
        chk("R10 first st0", sense_b0_o, 8'h21);
        chk("R10 first pcn", sense_b1_o, 8'd3);
        issue(0, 0, 0, 1, 2'd0, 0, 8'd0);
        chk("R10 second st0", sense_b0_o, 8'h26);
        chk("R10 second pcn", sense_b1_o, 8'd9);
        chk("R9 all cleared", {7'b0, int_pend_o}, 8'h00);
        issue(0, 0, 0, 1, 2'd0, 0, 8'd0);
        chk("R8 after drain", sense_b0_o, 8'h80);

        // R11 coincident seek and sense
        issue(1, 0, 0, 1, 2'd3, 0, 8'd4);
        chk("R11 sense ignored", {7'b0, sense_done_o}, 8'h00);
        view(2'd3);
        chk("R11 seek taken", pcn_o, 8'd4);
        issue(0, 0, 0, 1, 2'd0, 0, 8'd0);
        chk("R11 later report", sense_b0_o, 8'h23);
        chk("R11 later pcn", sense_b1_o, 8'd4);

        // R11 inward beats outward
        issue(0, 1, 1, 0, 2'd3, 0, 8'd2);
        chk("R11 inward wins", pcn_o, 8'd6);

        // table walk: R5 R6 R7
        do_reset();
        media_i = 4'b1111;
        for (int t = 0; t < 8; t++) begin
            logic [20:0] e;
            e = TBL[t];
            issue(e[20:19] == 2'd0, e[20:19] == 2'd1, e[20:19] == 2'd2, 0,
                  e[18:17], e[16], e[15:8]);
            view(e[18:17]);
            case (e[20:19])
                2'd0:    chk("R5 table", pcn_o, e[7:0]);
                2'd1:    chk("R6 table", pcn_o, e[7:0]);
                default: chk("R7 table", pcn_o, e[7:0]);
            endcase
        end
        view(2'd2);
        chk("R3 table same cyl", dir_o, 8'h80);
        view(2'd1);
        chk("R4 table stepped", dir_o, 8'h00);

        finish_run();
    end

endmodule